// File: doc/BRIEF.md
# Pulse Period and Width Measurement Timer

This block is one 16-bit timer channel that measures how long an external signal stays between two chosen transitions. A free-running prescaler derives a count tick from the base clock, from the base clock divided by two, eight or thirty-two, or from an external slow-clock enable. The measured input passes through a two-flop synchronizer and is compared against its previous tick-sampled value, so transitions are only recognised on count ticks.

Software programs a six-bit mode register with the tick source, the edge selection and the operating mode, and then sets a one-bit start register. Once running, the channel counts ticks; on every measuring edge it copies the running count into a read-only capture register, restarts the count from zero and emits a one-clock completion pulse. The first measuring edge after start only arms the channel. A sticky overflow flag reports that the counter wrapped past its maximum; software clears it by rewriting the mode register during a count tick that follows the one that set it.

Top module: `pulse_meas_timer`

## Requirements
- R1: After reset, mode_rdata, capture_q, ovf_flag and meas_done are all 0.
- R2: mode_rdata returns the last value written with mode_wr; bits [1:0] hold the tick source, bits [3:2] the edge selection, bits [5:4] the operating mode.
- R3: The channel measures only while the start bit is 1, the operating mode is 2'b10 and the edge selection is not 2'b11; otherwise meas_done stays 0 and capture_q keeps its value.
- R4: Edge selection 2'b01 measures rise-to-rise periods: capture_q receives the number of ticks between two consecutive rising edges minus one.
- R5: Edge selection 2'b00 measures fall-to-fall periods in the same way, and rising edges then complete nothing.
- R6: Edge selection 2'b10 completes on every edge: after a falling edge capture_q holds the high time minus one tick, after a rising edge the low time minus one tick.
- R7: The first measuring edge after the start bit is set only arms the channel and raises no meas_done.
- R8: Tick source 2'b00 ticks every clock when base_half is 0 and on every second clock when it is 1; 2'b01 divides by 8 and 2'b10 by 32; 2'b11 ticks on each slow_en high cycle. A divided tick falls on the n-th clock edge after reset release where n is a multiple of the divisor.
- R9: meas_done is high for exactly one clock per completed measurement, on the cycle capture_q takes its new value.
- R10: ovf_flag is set on the tick where the counter wraps from its all-ones value without a measuring edge.
- R11: ovf_flag clears only when mode_wr is asserted while the start bit is 1, on a tick cycle after the flag was set; a write on a non-tick cycle or with the start bit 0 leaves it set.
- R12: Clearing the start bit stops counting and keeps capture_q and ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_half | input | 1 | Halves the base tick source when 1 |
| slow_en | input | 1 | External slow-clock tick enable |
| meas_in | input | 1 | Asynchronous signal to measure |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode register write data |
| start_wr | input | 1 | Start register write strobe |
| start_wdata | input | 1 | Start register write data |
| mode_rdata | output | 6 | Mode register contents |
| start_q | output | 1 | Start register contents |
| capture_q | output | 16 | Last captured count |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| meas_done | output | 1 | One-clock measurement complete pulse |

## Verification
A wrong arming or edge-selection state shows at the ports as a completion pulse one edge too early, a missing pulse, or a capture value off by a whole period, all visible by the second measuring edge after start. A wrong prescaler phase or tick rate scales every captured value, so it shows on the first completed measurement. A wrong overflow clear condition only becomes visible after a full wrap of the counter, which is why the bench spends most of its cycles running one wrap at half rate and then probes writes on tick and non-tick cycles by counting clock edges from reset.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   typedef enum logic [1:0] {
      SRC_BASE  = 2'b00,
      SRC_DIV_A = 2'b01,
      SRC_DIV_B = 2'b10,
      SRC_SLOW  = 2'b11
   } tick_src_e;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_RSVD = 2'b11
   } edge_sel_e;

   localparam logic [1:0] OP_MEASURE = 2'b10;

   typedef struct packed {
      logic [1:0] op;
      edge_sel_e  sel;
      tick_src_e  src;
   } mode_t;

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler
   import pmt_pkg::*;
#(
   parameter int DIV_A = 8,
   parameter int DIV_B = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  tick_src_e src,
   input  logic      base_half,
   input  logic      slow_en,
   output logic      tick
);
   localparam int PW  = $clog2(DIV_B);
   localparam int AW  = $clog2(DIV_A);

   generate
      if (DIV_A < 2 || (1 << AW) != DIV_A) begin : g_bad_a
         $error("DIV_A must be a power of two of at least 2");
      end
      if (DIV_B <= DIV_A || (1 << PW) != DIV_B) begin : g_bad_b
         $error("DIV_B must be a power of two above DIV_A");
      end
   endgenerate

   logic [PW-1:0] phase_q;
   logic          tick_base, tick_a, tick_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   assign tick_base = base_half ? phase_q[0] : 1'b1;
   assign tick_a    = &phase_q[AW-1:0];
   assign tick_b    = &phase_q;

   always_comb begin
      unique case (src)
         SRC_BASE:  tick = tick_base;
         SRC_DIV_A: tick = tick_a;
         SRC_DIV_B: tick = tick_b;
         default:   tick = slow_en;
      endcase
   end

   // divided ticks never come back to back
   assert_divided_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && src == SRC_DIV_B && $past(src == SRC_DIV_B)) |-> !$past(tick));
   assert_half_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && src == SRC_BASE && base_half && $past(src == SRC_BASE && base_half))
      |-> !$past(tick));

endmodule

// File: rtl/pmt_edge_detect.sv
module pmt_edge_detect
   import pmt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  logic      tick,
   input  edge_sel_e sel,
   output logic      edge_hit
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   level, prev_q, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end

   assign level = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= 1'b0;
      else if (tick) prev_q <= level;
   end

   assign rise = tick &&  level && !prev_q;
   assign fall = tick && !level &&  prev_q;

   always_comb begin
      unique case (sel)
         EDGE_FALL: edge_hit = fall;
         EDGE_RISE: edge_hit = rise;
         EDGE_BOTH: edge_hit = rise || fall;
         default:   edge_hit = 1'b0;
      endcase
   end

   assert_edge_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |-> tick);
   assert_reserved_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EDGE_RSVD) |-> !edge_hit);

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic             edge_hit,
   input  logic             clr_req,
   output logic [CNT_W-1:0] capture_q,
   output logic             ovf_q,
   output logic             done_q
);
   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             complete, wrap;

   assign complete = active && tick && edge_hit && armed_q;
   assign wrap     = active && tick && !edge_hit && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!active) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (tick) begin
         if (edge_hit) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         capture_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= complete;
         if (complete) capture_q <= cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovf_q <= 1'b0;
      else if (wrap)              ovf_q <= 1'b1;
      else if (clr_req && ovf_q)  ovf_q <= 1'b0;
   end

   assert_capture_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(capture_q) |-> done_q);
   assert_idle_no_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !done_q);
   assert_ovf_sets_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(tick && active));
   assert_ovf_clear_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_q) |-> $past(clr_req));

endmodule

// File: rtl/pulse_meas_timer.sv
module pulse_meas_timer
   import pmt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_A       = 8,
   parameter int DIV_B       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_half,
   input  logic             slow_en,
   input  logic             meas_in,
   input  logic             mode_wr,
   input  logic [5:0]       mode_wdata,
   input  logic             start_wr,
   input  logic             start_wdata,
   output logic [5:0]       mode_rdata,
   output logic             start_q,
   output logic [CNT_W-1:0] capture_q,
   output logic             ovf_flag,
   output logic             meas_done
);
   mode_t mode_q;
   logic  tick, edge_hit, active, clr_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= mode_t'(mode_wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        start_q <= 1'b0;
      else if (start_wr) start_q <= start_wdata;
   end

   assign mode_rdata = mode_q;
   assign active     = start_q && (mode_q.op == OP_MEASURE) && (mode_q.sel != EDGE_RSVD);
   assign clr_req    = mode_wr && start_q && tick;

   pmt_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (mode_q.src),
      .base_half (base_half),
      .slow_en   (slow_en),
      .tick      (tick)
   );

   pmt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (meas_in),
      .tick     (tick),
      .sel      (mode_q.sel),
      .edge_hit (edge_hit)
   );

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .tick      (tick),
      .edge_hit  (edge_hit),
      .clr_req   (clr_req),
      .capture_q (capture_q),
      .ovf_q     (ovf_flag),
      .done_q    (meas_done)
   );

   assert_stopped_keeps_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q && $past(!start_q)) |-> $stable(ovf_flag));
   assert_done_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      meas_done |-> $past(start_q));

endmodule

// File: tb/pulse_meas_timer_test.sv
module pulse_meas_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_half = 1'b0;
   logic        slow_en = 1'b0;
   logic        meas_in = 1'b0;
   logic        mode_wr = 1'b0;
   logic [5:0]  mode_wdata = '0;
   logic        start_wr = 1'b0;
   logic        start_wdata = 1'b0;
   logic [5:0]  mode_rdata;
   logic        start_q;
   logic [15:0] capture_q;
   logic        ovf_flag;
   logic        meas_done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit finished = 0;

   bit gen_on = 0;
   int gen_hi = 10;
   int gen_lo = 10;
   logic man_lvl = 1'b0;

   pulse_meas_timer uut (
      .clk(clk), .rst_n(rst_n), .base_half(base_half), .slow_en(slow_en),
      .meas_in(meas_in), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .start_wr(start_wr), .start_wdata(start_wdata), .mode_rdata(mode_rdata),
      .start_q(start_q), .capture_q(capture_q), .ovf_flag(ovf_flag),
      .meas_done(meas_done)
   );

   always #10 clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   initial begin
      forever begin
         slow_en = 1'b0;
         repeat (4) @(negedge clk);
         slow_en = 1'b1;
         @(negedge clk);
      end
   end

   initial begin
      forever begin
         if (gen_on) begin
            meas_in = 1'b1;
            repeat (gen_hi) @(negedge clk);
            meas_in = 1'b0;
            repeat (gen_lo) @(negedge clk);
         end else begin
            meas_in = man_lvl;
            @(negedge clk);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic write_mode(input logic [1:0] op, input logic [1:0] sel, input logic [1:0] src);
      @(negedge clk);
      mode_wr = 1'b1; mode_wdata = {op, sel, src};
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic write_start(input logic v);
      @(negedge clk);
      start_wr = 1'b1; start_wdata = v;
      @(negedge clk);
      start_wr = 1'b0;
   endtask

   task automatic wait_done(input int lim, output bit got);
      got = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (meas_done) begin got = 1; break; end
      end
   endtask

   task automatic count_dones(input int n, output int dn);
      dn = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (meas_done) dn++;
      end
   endtask

   task automatic t_reset();
      chk(mode_rdata == 6'd0, "R1 mode", mode_rdata, 0);
      chk(capture_q == 16'd0, "R1 capture", capture_q, 0);
      chk(ovf_flag == 1'b0, "R1 ovf", ovf_flag, 0);
      chk(meas_done == 1'b0, "R1 done", meas_done, 0);
   endtask

   task automatic t_mode_reg();
      write_mode(2'b01, 2'b10, 2'b11);
      chk(mode_rdata == 6'b011011, "R2 readback", mode_rdata, 6'b011011);
      write_mode(2'b10, 2'b01, 2'b00);
      chk(mode_rdata == 6'b100100, "R2 readback", mode_rdata, 6'b100100);
   endtask

   // periodic measurement; expected capture in ticks
   task automatic t_period(input string req, input logic [1:0] sel, input logic [1:0] src,
                           input logic half, input int hi, input int lo, input int exp);
      bit got;
      int dn;
      write_start(1'b0);
      base_half = half;
      gen_hi = hi; gen_lo = lo; gen_on = 1;
      write_mode(2'b10, sel, src);
      repeat (2 * (hi + lo)) @(negedge clk);
      write_start(1'b1);
      for (int k = 0; k < 2; k++) begin
         wait_done(4 * (hi + lo) + 8, got);
         chk(got, req, got, 1);
         chk(capture_q == exp[15:0], req, capture_q, exp);
         @(negedge clk);
         chk(!meas_done, "R9 single pulse", meas_done, 0);
      end
      count_dones(3 * (hi + lo), dn);
      chk(dn == 3, {req, " one per period"}, dn, 3);
   endtask

   task automatic t_width();
      bit got;
      write_start(1'b0);
      base_half = 1'b0;
      gen_hi = 7; gen_lo = 13; gen_on = 1;
      write_mode(2'b10, 2'b10, 2'b00);
      repeat (40) @(negedge clk);
      write_start(1'b1);
      for (int k = 0; k < 4; k++) begin
         wait_done(40, got);
         chk(got, "R6 width done", got, 1);
         if (meas_in == 1'b0) chk(capture_q == 16'd6, "R6 high time", capture_q, 6);
         else                 chk(capture_q == 16'd12, "R6 low time", capture_q, 12);
      end
   endtask

   task automatic t_arm();
      int dn;
      bit got;
      write_start(1'b0);
      gen_on = 0; man_lvl = 1'b0; base_half = 1'b0;
      write_mode(2'b10, 2'b01, 2'b00);
      repeat (10) @(negedge clk);
      write_start(1'b1);
      man_lvl = 1'b1;
      count_dones(30, dn);
      chk(dn == 0, "R7 first edge arms only", dn, 0);
      man_lvl = 1'b0;
      repeat (20) @(negedge clk);
      man_lvl = 1'b1;
      wait_done(20, got);
      chk(got, "R7 second edge completes", got, 1);
      chk(capture_q == 16'd49, "R7 second edge completes", capture_q, 49);
   endtask

   task automatic t_idle();
      int dn;
      logic [15:0] keep;
      keep = capture_q;
      write_start(1'b0);
      gen_hi = 5; gen_lo = 6; gen_on = 1;
      write_mode(2'b10, 2'b11, 2'b00);
      write_start(1'b1);
      count_dones(100, dn);
      chk(dn == 0, "R3 reserved select", dn, 0);
      chk(capture_q == keep, "R3 reserved select capture", capture_q, keep);
      write_mode(2'b00, 2'b01, 2'b00);
      count_dones(100, dn);
      chk(dn == 0, "R3 other op mode", dn, 0);
      write_mode(2'b10, 2'b01, 2'b00);
      write_start(1'b0);
      count_dones(100, dn);
      chk(dn == 0, "R12 stopped no done", dn, 0);
      chk(capture_q == keep, "R12 capture kept", capture_q, keep);
   endtask

   task automatic t_overflow();
      write_start(1'b0);
      gen_on = 0; man_lvl = 1'b0; base_half = 1'b1;
      write_mode(2'b10, 2'b01, 2'b00);
      write_start(1'b1);
      repeat (130900) @(negedge clk);
      chk(ovf_flag == 1'b0, "R10 no early overflow", ovf_flag, 0);
      repeat (400) @(negedge clk);
      chk(ovf_flag == 1'b1, "R10 overflow set", ovf_flag, 1);
      // non-tick write: the write lands on edge cyc+1, odd
      while (cyc % 2 != 0) @(negedge clk);
      mode_wr = 1'b1; mode_wdata = 6'b100100;
      @(negedge clk);
      mode_wr = 1'b0;
      chk(ovf_flag == 1'b1, "R11 non-tick write keeps flag", ovf_flag, 1);
      write_start(1'b0);
      write_mode(2'b10, 2'b01, 2'b00);
      write_mode(2'b10, 2'b01, 2'b00);
      chk(ovf_flag == 1'b1, "R11 stopped write keeps flag", ovf_flag, 1);
      repeat (20) @(negedge clk);
      chk(ovf_flag == 1'b1, "R12 flag kept when stopped", ovf_flag, 1);
      write_start(1'b1);
      while (cyc % 2 != 1) @(negedge clk);
      mode_wr = 1'b1; mode_wdata = 6'b100100;
      @(negedge clk);
      mode_wr = 1'b0;
      chk(ovf_flag == 1'b0, "R11 tick write clears flag", ovf_flag, 0);
   endtask

   initial begin
      repeat (195000) @(negedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_reg();
      t_period("R4 rise period base", 2'b01, 2'b00, 1'b0, 10, 15, 24);
      t_period("R5 fall period base", 2'b00, 2'b00, 1'b0, 12, 18, 29);
      t_period("R8 half base", 2'b01, 2'b00, 1'b1, 20, 20, 19);
      t_period("R8 divide by 8", 2'b01, 2'b01, 1'b0, 40, 40, 9);
      t_period("R8 divide by 32", 2'b00, 2'b10, 1'b0, 160, 160, 9);
      t_period("R8 slow enable", 2'b01, 2'b11, 1'b0, 25, 25, 9);
      t_width();
      t_arm();
      t_idle();
      t_overflow();
      summary();
   end
endmodule